// File: doc/BRIEF.md
# Glitch Detector and Latch

This block watches a set of logic channels that are oversampled by a fast internal clock. Every acquisition sample interval spans a fixed number of sub-samples. When a channel toggles more than once inside one interval, a pulse shorter than the sample interval went by, and the block marks that channel as glitched. The mark is held as a flag exactly one sample interval long, so a glitch of any narrowness shows up as a one-sample event.

For each interval the flag vector is written into a dedicated glitch store. That store is separate from the data samples but is addressed by the same write pointer, so each glitch entry matches the data word of the same interval. A trigger output fires when a flagged channel is also enabled in the operator's mask. It can be used on its own, or gated with an external word-recognition signal through an AND or an OR.

Top module: `glitch_latch`

## Requirements
- R1: On a synchronous reset, `glitch_flags`, `sample_stb` and `glitch_trig` are 0, `wr_addr` is 0, and the first rising edge after release handles sub-sample 0 of a new interval.
- R2: A transition is a sub-sample that differs from the sub-sample before it, and the last sub-sample of the previous interval counts as "before" for sub-sample 0. When a channel makes two or more transitions within one interval of SUBS sub-samples, bit i of the flag vector (channel i) is set for that interval.
- R3: A channel with zero transitions or one transition in an interval is not flagged. A one-sub-sample pulse whose two edges fall in different intervals is not flagged either.
- R4: `glitch_flags` takes a new value only on the edge that ends an interval. It then holds for exactly SUBS clocks. `sample_stb` is high for one clock after each such edge.
- R5: Each interval's flag vector is written to the glitch store at `wr_addr`. `wr_addr` then increases by one and wraps from 2^AW-1 to 0.
- R6: `rd_flags` combinationally returns the stored vector at `rd_addr`.
- R7: Only channels with a 1 in `chan_en` can contribute to the glitch part of the trigger.
- R8: `comb_mode` 0: `glitch_trig` = enabled glitch present.
- R9: `comb_mode` 1: `glitch_trig` = enabled glitch AND `word_match`.
- R10: `comb_mode` 2: `glitch_trig` = enabled glitch OR `word_match`.
- R11: `comb_mode` 3 behaves like mode 0, so `word_match` has no effect.
- R12: `glitch_trig` is a one-clock pulse that coincides with `sample_stb`. `chan_en`, `comb_mode` and `word_match` are sampled in the last sub-sample clock of the interval.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sub-sample clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_in | input | NCH | Oversampled channel bits, one sub-sample per clock |
| chan_en | input | NCH | Per-channel glitch trigger enable |
| comb_mode | input | 2 | 0 glitch only, 1 AND, 2 OR, 3 glitch only |
| word_match | input | 1 | Word-recognition result for the interval |
| glitch_flags | output | NCH | Latched glitch flags, one interval wide |
| sample_stb | output | 1 | One-clock pulse per completed interval |
| glitch_trig | output | 1 | Trigger pulse |
| wr_addr | output | AW | Next glitch store write address, shared with data store |
| rd_addr | input | AW | Glitch store read address |
| rd_flags | output | NCH | Glitch store read data |

## Verification
The bench checks a single clean edge against a real double toggle. Code that flags on any edge would mark the clean case. It runs a narrow pulse that crosses an interval boundary, which code that keeps counting transitions across intervals would flag by mistake. It walks all four combine modes with the match input both high and low, where swapped AND/OR decoding or a mode 3 that reads `word_match` would give the wrong trigger. It also masks a glitched channel, where an unmasked OR would still fire. Further runs wrap the write address, which shows an off-by-one pointer or a wrong wrap width. A reset in the middle of an interval shows whether the sub-sample phase realigns.

// File: rtl/glitch_latch_pkg.sv
`timescale 1ns/1ps
package glitch_latch_pkg;

  typedef enum logic [1:0] {
    CM_GLITCH = 2'd0,
    CM_AND    = 2'd1,
    CM_OR     = 2'd2,
    CM_RSVD   = 2'd3
  } comb_mode_e;

  // saturating transition counter step: 0,1,2 where 2 means "two or more"
  function automatic logic [1:0] trans_step(input logic [1:0] cnt, input logic edge_seen);
    logic [2:0] sum;
    sum = {1'b0, cnt} + {2'b00, edge_seen};
    trans_step = (sum >= 3'd2) ? 2'd2 : sum[1:0];
  endfunction

  function automatic logic trig_combine(input logic [1:0] mode, input logic hit,
                                        input logic match);
    case (comb_mode_e'(mode))
      CM_AND:  trig_combine = hit & match;
      CM_OR:   trig_combine = hit | match;
      default: trig_combine = hit;
    endcase
  endfunction

endpackage

// File: rtl/glitch_latch_chan.sv
`timescale 1ns/1ps
module glitch_latch_chan
  import glitch_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic last,
  output logic glitch_now
);
  logic       prev_q;
  logic [1:0] cnt_q;
  logic       edge_seen;
  logic [1:0] total;

  assign edge_seen  = din ^ prev_q;
  assign total      = trans_step(cnt_q, edge_seen);
  assign glitch_now = (total == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      prev_q <= din;
      cnt_q  <= last ? 2'd0 : total;
    end
  end
endmodule

// File: rtl/glitch_latch_timer.sv
`timescale 1ns/1ps
module glitch_latch_timer #(
  parameter int SUBS = 4,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic          last,
  output logic [AW-1:0] wr_addr
);
  localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1;
  localparam logic [SW-1:0] LAST_IDX = SW'(SUBS - 1);

  logic [SW-1:0] sub_q;

  assign last = (sub_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      wr_addr <= '0;
    end else begin
      sub_q <= last ? '0 : sub_q + 1'b1;
      if (last) wr_addr <= wr_addr + 1'b1;
    end
  end
endmodule

// File: rtl/glitch_latch_mem.sv
`timescale 1ns/1ps
module glitch_latch_mem #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [NCH-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [NCH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NCH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/glitch_latch.sv
`timescale 1ns/1ps
module glitch_latch
  import glitch_latch_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int SUBS = 4,
  parameter int AW   = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_in,
  input  logic [NCH-1:0] chan_en,
  input  logic [1:0]     comb_mode,
  input  logic           word_match,
  output logic [NCH-1:0] glitch_flags,
  output logic           sample_stb,
  output logic           glitch_trig,
  output logic [AW-1:0]  wr_addr,
  input  logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] rd_flags
);
  // named internal events, visible to the bound checker
  logic           ivl_end;
  logic [NCH-1:0] det_vec;
  logic           en_hit;

  glitch_latch_timer #(.SUBS(SUBS), .AW(AW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .last    (ivl_end),
    .wr_addr (wr_addr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    glitch_latch_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .din        (chan_in[i]),
      .last       (ivl_end),
      .glitch_now (det_vec[i])
    );
  end

  assign en_hit = |(det_vec & chan_en);

  glitch_latch_mem #(.NCH(NCH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (ivl_end),
    .waddr (wr_addr),
    .wdata (det_vec),
    .raddr (rd_addr),
    .rdata (rd_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glitch_flags <= '0;
      sample_stb   <= 1'b0;
      glitch_trig  <= 1'b0;
    end else begin
      sample_stb  <= ivl_end;
      glitch_trig <= ivl_end & trig_combine(comb_mode, en_hit, word_match);
      if (ivl_end) glitch_flags <= det_vec;
    end
  end
endmodule

// File: rtl/glitch_latch_chk.sv
`timescale 1ns/1ps
module glitch_latch_chk #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           ivl_end,
  input logic [NCH-1:0] chan_en,
  input logic [1:0]     comb_mode,
  input logic           word_match,
  input logic [NCH-1:0] glitch_flags,
  input logic           sample_stb,
  input logic           glitch_trig,
  input logic [AW-1:0]  wr_addr
);
  p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !$past(rst)) |-> $stable(glitch_flags));

  p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !$past(rst)) |-> $stable(wr_addr));

  p_trig_with_stb_r12: assert property (@(posedge clk) disable iff (rst)
    glitch_trig |-> sample_stb);

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (ivl_end && chan_en == '0 && comb_mode == 2'd0) |=> !glitch_trig);

  p_or_match_r10: assert property (@(posedge clk) disable iff (rst)
    (ivl_end && comb_mode == 2'd2 && word_match) |=> glitch_trig);

  p_and_nomatch_r9: assert property (@(posedge clk) disable iff (rst)
    (ivl_end && comb_mode == 2'd1 && !word_match) |=> !glitch_trig);
endmodule

bind glitch_latch glitch_latch_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ivl_end      (ivl_end),
  .chan_en      (chan_en),
  .comb_mode    (comb_mode),
  .word_match   (word_match),
  .glitch_flags (glitch_flags),
  .sample_stb   (sample_stb),
  .glitch_trig  (glitch_trig),
  .wr_addr      (wr_addr)
);

// File: tb/glitch_latch_tb.sv
`timescale 1ns/1ps
module glitch_latch_tb;
  localparam int NCH  = 8;
  localparam int SUBS = 4;
  localparam int AW   = 6;
  localparam int NV   = 14;

  // sub-sample k of a vector lives in bits [8k+7:8k]
  localparam logic [31:0] T_PAT [NV] = '{
    32'h00000000, 32'h01010101, 32'h01010301, 32'h00040000,
    32'h80000000, 32'h00000000, 32'h00000008, 32'h00000008,
    32'h00000000, 32'h00000000, 32'h00100010, 32'h00000000,
    32'h00FF00FF, 32'h00FF00FF };
  localparam logic [7:0] T_EN [NV] = '{
    8'hFF, 8'hFF, 8'hFF, 8'hFB, 8'hFF, 8'hFF, 8'hFF,
    8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00 };
  localparam logic [1:0] T_MODE [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1,
    2'd1, 2'd2, 2'd2, 2'd3, 2'd3, 2'd0, 2'd2 };
  localparam logic T_MATCH [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1 };
  localparam logic [7:0] T_FLAGS [NV] = '{
    8'h00, 8'h00, 8'h02, 8'h04, 8'h00, 8'h00, 8'h08,
    8'h08, 8'h00, 8'h00, 8'h10, 8'h00, 8'hFF, 8'hFF };
  localparam logic T_TRIG [NV] = '{
    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1 };
  localparam string T_TAG [NV] = '{
    "R3", "R3", "R2", "R7", "R3", "R3", "R9",
    "R9", "R10", "R10", "R11", "R11", "R7", "R10" };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chan_in = '0;
  logic [NCH-1:0] chan_en = '0;
  logic [1:0]     comb_mode = 2'd0;
  logic           word_match = 1'b0;
  logic [NCH-1:0] glitch_flags;
  logic           sample_stb;
  logic           glitch_trig;
  logic [AW-1:0]  wr_addr;
  logic [AW-1:0]  rd_addr = '0;
  logic [NCH-1:0] rd_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  glitch_latch #(.NCH(NCH), .SUBS(SUBS), .AW(AW)) u_dut (
    .clk (clk), .rst (rst), .chan_in (chan_in), .chan_en (chan_en),
    .comb_mode (comb_mode), .word_match (word_match),
    .glitch_flags (glitch_flags), .sample_stb (sample_stb),
    .glitch_trig (glitch_trig), .wr_addr (wr_addr),
    .rd_addr (rd_addr), .rd_flags (rd_flags));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the falling edge
  // that follows the interval-ending rising edge
  task automatic run_ivl(input logic [31:0] pat, input logic [7:0] en, input logic [1:0] mode,
                         input logic match, input logic [7:0] exp_flags, input logic exp_trig,
                         input string tag);
    logic [7:0] held;
    held = glitch_flags;
    chan_en = en;
    comb_mode = mode;
    word_match = match;
    for (int k = 0; k < SUBS; k++) begin
      chan_in = pat[8*k +: 8];
      @(posedge clk);
      @(negedge clk);
      if (k < SUBS - 1) begin
        chk("R4 flags held mid-interval", 32'(glitch_flags), 32'(held));
        chk("R4 strobe low mid-interval", 32'(sample_stb), 32'd0);
        chk("R12 trig low mid-interval", 32'(glitch_trig), 32'd0);
      end
    end
    exp_addr = exp_addr + 1'b1;
    chk({tag, " flags"}, 32'(glitch_flags), 32'(exp_flags));
    chk({tag, " trig"}, 32'(glitch_trig), 32'(exp_trig));
    chk("R4 strobe at interval end", 32'(sample_stb), 32'd1);
    chk("R5 write address", 32'(wr_addr), 32'(exp_addr));
    rd_addr = exp_addr - 1'b1;
    #1;
    chk("R6 R5 stored flags", 32'(rd_flags), 32'(exp_flags));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while held in reset
    chk("R1 flags in reset", 32'(glitch_flags), 32'd0);
    chk("R1 strobe in reset", 32'(sample_stb), 32'd0);
    chk("R1 trig in reset", 32'(glitch_trig), 32'd0);
    chk("R1 address in reset", 32'(wr_addr), 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_ivl(T_PAT[v], T_EN[v], T_MODE[v], T_MATCH[v], T_FLAGS[v], T_TRIG[v], T_TAG[v]);

    // R8: explicit glitch-only mode, match low and high
    run_ivl(32'h00000040, 8'h40, 2'd0, 1'b0, 8'h40, 1'b1, "R8");
    run_ivl(32'h00000000, 8'hFF, 2'd0, 1'b1, 8'h00, 1'b0, "R8");

    // R5: fill the rest of the store so the address wraps to 0
    for (int n = NV + 2; n < (1 << AW); n++)
      run_ivl(32'h0, 8'hFF, 2'd0, 1'b0, 8'h00, 1'b0, "R3");
    chk("R5 address wrapped", 32'(wr_addr), 32'd0);

    // R1: reset halfway through an interval with a partial glitch on channel 5
    chan_in = 8'h20;
    @(posedge clk);
    @(negedge clk);
    chan_in = 8'h00;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 flags after mid reset", 32'(glitch_flags), 32'd0);
    chk("R1 strobe after mid reset", 32'(sample_stb), 32'd0);
    chk("R1 address after mid reset", 32'(wr_addr), 32'd0);
    exp_addr = '0;
    run_ivl(32'h00000020, 8'h20, 2'd0, 1'b0, 8'h20, 1'b1, "R1 R2 realigned");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule